// File: doc/BRIEF.md
# Single-Line Bus Master Transaction Engine

This block is the master side of a single-wire, open-drain serial bus. One command can ask for a bus reset and a data transfer of one to four bytes. If it asks for both, the engine first drives the reset pulse and samples the slave's presence response. It then clocks out the data slots. Each slot is generated from a microsecond tick derived from the system clock, using standard-speed bus timing. The engine never drives the line high. It asserts `line_oe` to pull the wire low and reads the wire back through `line_in`.

The data transfer follows one rule for every bit. A transmitted 0 is a write-0 slot. A transmitted 1 is a short slot in which the line is sampled. The sampled value is stored in the receive word at the same bit position. This one rule gives pure writes, pure reads (transmit all ones) and any mix of the two, down to single bits. Two completion events, end of transfer and missing presence, set sticky flags. Each flag is cleared by writing one to it, and each can raise the interrupt through its own enable.

Software loads the transmit word and the command fields together with a one-cycle `cmd_we` strobe. It waits for `busy` to fall, or for the interrupt, and then reads `rx_word`.

Top module: `ow_txn_engine`

## Requirements
- R1: After reset, `line_oe`, `busy`, `stat_done`, `stat_nopres` and `irq` are 0 and `rx_word` is all zeros.
- R2: A `cmd_we` strobe is accepted only while `busy` is 0 and at least one of `cmd_bus_reset` and `cmd_xfer` is 1. Any other strobe is ignored: no line activity and no change to flags or to the result.
- R3: A reset-only command holds the line low for 480 µs. It keeps `busy` high for 960 µs in total. One µs is TICK_DIV clock cycles.
- R4: At the end of a reset, if the line was sampled high 70 µs after release, `stat_nopres` is set. If a slave was pulling it low, the flag is not set.
- R5: With `cmd_skip_presence` set, a missing presence response does not set `stat_nopres`.
- R6: `cmd_size` code n transfers 8·(n+1) bits. The bits are sent least significant first, starting from bit 0 of `tx_word`.
- R7: A transmitted 0 holds the line low for 60 µs. A transmitted 1 holds it low for 6 µs and is sampled 15 µs after the slot starts. Consecutive slots start 70 µs apart.
- R8: A transfer clears `rx_word` when it starts. Each bit i of the transfer then stores `tx_word[i]` AND the sampled line, so bits written as 0 read 0 and bits outside the transfer stay 0.
- R9: With both the reset and the transfer requested, the first data slot starts 960 µs after the reset pulse starts. `busy` stays high for (960 + 70·bits) µs.
- R10: `stat_done` is set when the whole command has finished. This covers a reset-only command.
- R11: `stat_done` (clear bit 0) and `stat_nopres` (clear bit 1) stay set until a 1 is pulsed on their bit of `stat_clr`.
- R12: `irq` is 1 exactly while (`stat_done` and `irq_en_done`) or (`stat_nopres` and `irq_en_nopres`) holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | One-cycle command strobe |
| cmd_bus_reset | input | 1 | Request a reset slot with presence check |
| cmd_xfer | input | 1 | Request a data transfer |
| cmd_size | input | SIZE_W | Byte count minus one |
| cmd_skip_presence | input | 1 | Do not flag a missing presence response |
| tx_word | input | DATA_W | Transmit bits, sampled at command accept |
| irq_en_done | input | 1 | Interrupt enable for completion |
| irq_en_nopres | input | 1 | Interrupt enable for missing presence |
| stat_clr | input | 2 | Write-one-to-clear pulse: bit 0 done, bit 1 no-presence |
| line_in | input | 1 | Sampled bus line level |
| line_oe | output | 1 | 1 pulls the bus line low |
| rx_word | output | DATA_W | Received bits |
| busy | output | 1 | Command in progress |
| stat_done | output | 1 | Sticky completion flag |
| stat_nopres | output | 1 | Sticky missing-presence flag |
| irq | output | 1 | Interrupt request |

## Verification
A corrupt slot counter shows up at the ports as a wrong low-pulse width or slot spacing on `line_oe` within that same slot. A bit index that skips or repeats shows up as a wrong slot count or wrong `busy` length. The bench measures both to the cycle on every transfer. A sampling error, such as the wrong moment, the wrong bit position or missing masking by the written bit, shows up in `rx_word` as soon as `busy` falls. The bench sweeps every size code against several transmit and slave response patterns, so each bit position is checked both as written 0 and as read.

// File: rtl/ow_pkg.sv
// Shared definitions for the bus master transaction engine.
// Assumes: timing is expressed in microsecond ticks, standard speed only.
package ow_pkg;

    typedef enum logic [1:0] {
        OW_IDLE = 2'd0,
        OW_RST  = 2'd1,
        OW_BIT  = 2'd2
    } ow_state_e;

    localparam int unsigned OW_US_W = 10;

    // Reset slot: low time, presence sample point, last microsecond of slot.
    localparam logic [OW_US_W-1:0] OW_RST_LOW    = 10'd480;
    localparam logic [OW_US_W-1:0] OW_RST_SAMPLE = 10'd550;
    localparam logic [OW_US_W-1:0] OW_RST_LAST   = 10'd959;

    // Data slot: write-0 low, write-1/read low, sample point, last microsecond.
    localparam logic [OW_US_W-1:0] OW_W0_LOW     = 10'd60;
    localparam logic [OW_US_W-1:0] OW_W1_LOW     = 10'd6;
    localparam logic [OW_US_W-1:0] OW_BIT_SAMPLE = 10'd15;
    localparam logic [OW_US_W-1:0] OW_BIT_LAST   = 10'd69;

endpackage

// File: rtl/ow_tick_gen.sv
// Microsecond tick prescaler.
// Produces a one-cycle tick every DIV clocks and restarts its phase on
// `restart` so every command begins on a whole microsecond.
// Assumes DIV >= 1; DIV == 1 yields a tick on every cycle.
module ow_tick_gen #(
    parameter int unsigned DIV = 100,
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    generate
        if (DIV == 1) begin : g_passthru
            logic unused_tick_inputs;
            assign unused_tick_inputs = restart ^ clk ^ rst_n;
            assign tick = 1'b1;
        end else begin : g_count
            localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            // Count clocks within one microsecond, wrapping at DIV-1.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/ow_sync.sv
// Input synchronizer for the sampled bus line.
// Resets to 1 (released bus level). Assumes STAGES >= 1.
module ow_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= d;
            end
        end else begin : g_many
            // Shift the line level through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ow_seq.sv
// Slot sequencer: runs an optional reset slot followed by an optional run
// of data slots, keeping transmit and receive words.
// Each transmitted 1 is a read slot whose sampled level is stored in place.
// Assumes MAX_BYTES is a power of two >= 2 and `tick` marks microseconds.
module ow_seq
    import ow_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 4,
    localparam int unsigned DATA_W = 8 * MAX_BYTES,
    localparam int unsigned SIZE_W = $clog2(MAX_BYTES),
    localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_we,
    input  logic              cmd_bus_reset,
    input  logic              cmd_xfer,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              cmd_skip_presence,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              line_s,
    output logic              accept,
    output logic              line_oe,
    output logic              busy,
    output logic [DATA_W-1:0] rx_word,
    output logic              done_set,
    output logic              nopres_set
);

    ow_state_e           state_q;
    logic [OW_US_W-1:0]  us_q;
    logic [IDX_W-1:0]    idx_q;
    logic [DATA_W-1:0]   tx_q;
    logic [DATA_W-1:0]   rx_q;
    logic [SIZE_W-1:0]   size_q;
    logic                xfer_q;
    logic                skip_q;
    logic                pres_q;
    logic                oe_q;

    logic [IDX_W-1:0]    last_idx;
    logic                cur_bit;
    logic [OW_US_W-1:0]  low_len;
    logic                slot_end;
    logic                at_sample;

    // Decode the current slot: last bit index, data bit, low time, end point.
    always_comb begin
        last_idx  = {size_q, 3'b111};
        cur_bit   = tx_q[idx_q];
        low_len   = cur_bit ? OW_W1_LOW : OW_W0_LOW;
        accept    = cmd_we && (state_q == OW_IDLE) && (cmd_bus_reset || cmd_xfer);
        slot_end  = 1'b0;
        at_sample = 1'b0;
        case (state_q)
            OW_RST: begin
                slot_end  = tick && (us_q == OW_RST_LAST);
                at_sample = tick && (us_q == OW_RST_SAMPLE);
            end
            OW_BIT: begin
                slot_end  = tick && (us_q == OW_BIT_LAST);
                at_sample = tick && (us_q == OW_BIT_SAMPLE);
            end
            default: ;
        endcase
    end

    // Completion and presence events raised on the last tick of a slot.
    always_comb begin
        done_set   = slot_end && (((state_q == OW_RST) && !xfer_q) ||
                                  ((state_q == OW_BIT) && (idx_q == last_idx)));
        nopres_set = slot_end && (state_q == OW_RST) && !pres_q && !skip_q;
    end

    // Main state machine: accept commands, step microseconds, slots and bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OW_IDLE;
            us_q    <= '0;
            idx_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            size_q  <= '0;
            xfer_q  <= 1'b0;
            skip_q  <= 1'b0;
            pres_q  <= 1'b0;
        end else begin
            case (state_q)
                OW_IDLE: begin
                    if (accept) begin
                        tx_q    <= tx_word;
                        size_q  <= cmd_size;
                        xfer_q  <= cmd_xfer;
                        skip_q  <= cmd_skip_presence;
                        pres_q  <= 1'b0;
                        us_q    <= '0;
                        idx_q   <= '0;
                        if (cmd_xfer) rx_q <= '0;
                        state_q <= cmd_bus_reset ? OW_RST : OW_BIT;
                    end
                end
                OW_RST: begin
                    if (at_sample && !line_s) pres_q <= 1'b1;
                    if (slot_end) begin
                        us_q    <= '0;
                        state_q <= xfer_q ? OW_BIT : OW_IDLE;
                    end else if (tick) begin
                        us_q <= us_q + 1'b1;
                    end
                end
                OW_BIT: begin
                    if (at_sample && cur_bit) rx_q[idx_q] <= line_s;
                    if (slot_end) begin
                        us_q <= '0;
                        if (idx_q == last_idx) state_q <= OW_IDLE;
                        else                   idx_q   <= idx_q + 1'b1;
                    end else if (tick) begin
                        us_q <= us_q + 1'b1;
                    end
                end
                default: state_q <= OW_IDLE;
            endcase
        end
    end

    // Registered line enable: low phase of the reset or data slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= ((state_q == OW_RST) && (us_q < OW_RST_LOW)) ||
                    ((state_q == OW_BIT) && (us_q < low_len));
        end
    end

    assign line_oe = oe_q;
    assign busy    = (state_q != OW_IDLE);
    assign rx_word = rx_q;

    // R1: a line enable never follows two idle cycles.
    a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OW_IDLE) && $past(state_q == OW_IDLE) |-> !oe_q);

    // R2: latched transmit word holds while a command is running.
    a_r2_busy_hold_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != OW_IDLE) |=> $stable(tx_q));

    // R3: line is released one microsecond after the reset low phase.
    a_r3_reset_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OW_RST) && (us_q == OW_RST_LOW + 10'd1) |-> !oe_q);

    // R6: bit index stays inside the requested size.
    a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OW_BIT) |-> (idx_q <= last_idx));

    // R8: receive word is stable while idle and no command arrives.
    a_r8_rx_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OW_IDLE) && !cmd_we |=> $stable(rx_q));

endmodule

// File: rtl/ow_status.sv
// Sticky status flags with write-one-to-clear and interrupt combining.
// A set event in the same cycle as a clear wins.
module ow_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done_set,
    input  logic       nopres_set,
    input  logic [1:0] stat_clr,
    input  logic       irq_en_done,
    input  logic       irq_en_nopres,
    output logic       stat_done,
    output logic       stat_nopres,
    output logic       irq
);

    logic done_q;
    logic nopres_q;

    // Hold each flag until its clear bit is pulsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            nopres_q <= 1'b0;
        end else begin
            done_q   <= done_set   || (done_q   && !stat_clr[0]);
            nopres_q <= nopres_set || (nopres_q && !stat_clr[1]);
        end
    end

    assign stat_done   = done_q;
    assign stat_nopres = nopres_q;
    assign irq         = (done_q && irq_en_done) || (nopres_q && irq_en_nopres);

    // R11: done flag persists without a clear.
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !stat_clr[0] |=> done_q);

    // R11: no-presence flag persists without a clear.
    a_r11_nopres_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        nopres_q && !stat_clr[1] |=> nopres_q);

    // R10: done flag rises only on a completion event.
    a_r10_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(done_set));

endmodule

// File: rtl/ow_txn_engine.sv
// Top level of the single-line bus master transaction engine.
// Connects the microsecond prescaler, line synchronizer, slot sequencer and
// status block. Assumes an external open-drain pad driven low by line_oe.
module ow_txn_engine #(
    parameter int unsigned MAX_BYTES   = 4,
    parameter int unsigned TICK_DIV    = 100,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned DATA_W = 8 * MAX_BYTES,
    localparam int unsigned SIZE_W = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              cmd_bus_reset,
    input  logic              cmd_xfer,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              cmd_skip_presence,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              irq_en_done,
    input  logic              irq_en_nopres,
    input  logic [1:0]        stat_clr,
    input  logic              line_in,
    output logic              line_oe,
    output logic [DATA_W-1:0] rx_word,
    output logic              busy,
    output logic              stat_done,
    output logic              stat_nopres,
    output logic              irq
);

    logic tick;
    logic accept;
    logic line_s;
    logic done_set;
    logic nopres_set;

    ow_tick_gen #(.DIV(TICK_DIV)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .tick    (tick)
    );

    ow_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    ow_seq #(.MAX_BYTES(MAX_BYTES)) seq_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .tick              (tick),
        .cmd_we            (cmd_we),
        .cmd_bus_reset     (cmd_bus_reset),
        .cmd_xfer          (cmd_xfer),
        .cmd_size          (cmd_size),
        .cmd_skip_presence (cmd_skip_presence),
        .tx_word           (tx_word),
        .line_s            (line_s),
        .accept            (accept),
        .line_oe           (line_oe),
        .busy              (busy),
        .rx_word           (rx_word),
        .done_set          (done_set),
        .nopres_set        (nopres_set)
    );

    ow_status status_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .done_set      (done_set),
        .nopres_set    (nopres_set),
        .stat_clr      (stat_clr),
        .irq_en_done   (irq_en_done),
        .irq_en_nopres (irq_en_nopres),
        .stat_done     (stat_done),
        .stat_nopres   (stat_nopres),
        .irq           (irq)
    );

endmodule

// File: tb/ow_txn_engine_tb.sv
// Self-checking bench with a behavioural slave on the bus line.
module ow_txn_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic        cmd_bus_reset = 1'b0;
    logic        cmd_xfer = 1'b0;
    logic [1:0]  cmd_size = 2'd0;
    logic        cmd_skip_presence = 1'b0;
    logic [31:0] tx_word = '0;
    logic        irq_en_done = 1'b0;
    logic        irq_en_nopres = 1'b0;
    logic [1:0]  stat_clr = 2'b00;
    logic        line_in;
    logic        line_oe;
    logic [31:0] rx_word;
    logic        busy;
    logic        stat_done;
    logic        stat_nopres;
    logic        irq;

    // Slave model controls and monitor log.
    logic [31:0] slv_mask = '1;
    logic        slv_present = 1'b1;
    logic        slave_pull = 1'b0;
    logic        log_clr = 1'b0;
    logic        oe_d = 1'b0;
    int          cyc = 0;
    int          rise_t = 0;
    int          np = 0;
    int          busy_cyc = 0;
    int          slot_idx = 0;
    int          pull_cnt = 0;
    int          pres_wait = 0;
    int          pres_cnt = 0;
    int          p_start [0:63];
    int          p_width [0:63];

    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_in = !(line_oe || slave_pull);

    ow_txn_engine #(.MAX_BYTES(4), .TICK_DIV(DIV), .SYNC_STAGES(2)) dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .cmd_we            (cmd_we),
        .cmd_bus_reset     (cmd_bus_reset),
        .cmd_xfer          (cmd_xfer),
        .cmd_size          (cmd_size),
        .cmd_skip_presence (cmd_skip_presence),
        .tx_word           (tx_word),
        .irq_en_done       (irq_en_done),
        .irq_en_nopres     (irq_en_nopres),
        .stat_clr          (stat_clr),
        .line_in           (line_in),
        .line_oe           (line_oe),
        .rx_word           (rx_word),
        .busy              (busy),
        .stat_done         (stat_done),
        .stat_nopres       (stat_nopres),
        .irq               (irq)
    );

    // Monitor low pulses on the line and play the slave's responses.
    always @(posedge clk) begin
        if (log_clr) begin
            np = 0; busy_cyc = 0; slot_idx = 0;
        end else if (busy) begin
            busy_cyc++;
        end
        if (line_oe && !oe_d) begin
            rise_t = cyc;
            if (np < 64) p_start[np] = cyc;
            if (slot_idx < 32 && !slv_mask[slot_idx]) pull_cnt = 30 * DIV;
            slot_idx++;
        end
        if (!line_oe && oe_d) begin
            if (np < 64) p_width[np] = cyc - rise_t;
            if (cyc - rise_t > 200 * DIV) begin
                slot_idx = 0;
                pull_cnt = 0;
                if (slv_present) pres_wait = 15 * DIV;
            end
            np++;
        end
        if (pull_cnt > 0) pull_cnt--;
        if (pres_wait > 0) begin
            pres_wait--;
            if (pres_wait == 0) pres_cnt = 120 * DIV;
        end else if (pres_cnt > 0) begin
            pres_cnt--;
        end
        slave_pull <= (pull_cnt > 0) || (pres_cnt > 0);
        oe_d = line_oe;
        cyc++;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic issue(input bit r, input bit o, input logic [1:0] sz,
                         input bit sk, input logic [31:0] tx, input bit clear_log);
        @(negedge clk);
        log_clr           = clear_log;
        cmd_bus_reset     = r;
        cmd_xfer          = o;
        cmd_size          = sz;
        cmd_skip_presence = sk;
        tx_word           = tx;
        cmd_we            = 1'b1;
        @(negedge clk);
        cmd_we  = 1'b0;
        log_clr = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flags();
        stat_clr = 2'b11;
        @(negedge clk);
        stat_clr = 2'b00;
        @(negedge clk);
    endtask

    // Run one command against the slave model and check every port-level effect.
    task automatic run_cmd(input bit r, input bit o, input logic [1:0] sz, input bit sk,
                           input logic [31:0] tx, input logic [31:0] mask, input bit present);
        int nbits;
        int off;
        int bad_w;
        int bad_s;
        logic [31:0] exp_rx;
        slv_mask    = mask;
        slv_present = present;
        issue(r, o, sz, sk, tx, 1'b1);
        wait_idle();
        nbits  = o ? 8 * (int'(sz) + 1) : 0;
        off    = r ? 1 : 0;
        exp_rx = '0;
        for (int i = 0; i < nbits; i++) exp_rx[i] = tx[i] & mask[i];
        if (o) chk("R8", "receive word", rx_word, exp_rx);
        chk("R6", "low pulse count", np, off + nbits);
        if (r) chk("R3", "reset low width", p_width[0], 480 * DIV);
        bad_w = 0;
        bad_s = 0;
        for (int i = 0; i < nbits; i++) begin
            if (p_width[off + i] != (tx[i] ? 6 : 60) * DIV) bad_w++;
            if (i > 0 && p_start[off + i] - p_start[off + i - 1] != 70 * DIV) bad_s++;
        end
        if (o) begin
            chk("R7", "slot low widths wrong", bad_w, 0);
            chk("R7", "slot spacings wrong", bad_s, 0);
        end
        if (r && o) chk("R9", "reset to first slot", p_start[1] - p_start[0], 960 * DIV);
        chk("R9", "busy cycles", busy_cyc, ((r ? 960 : 0) + 70 * nbits) * DIV);
        chk("R10", "done flag", stat_done, 1);
        if (r) chk(sk ? "R5" : "R4", "no-presence flag", stat_nopres, (!present && !sk) ? 1 : 0);
        clear_flags();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements: actual no completion expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    logic [31:0] tx_list [0:1];
    logic [31:0] mk_list [0:2];

    initial begin
        tx_list[0] = 32'hFFFF_FFFF;
        tx_list[1] = 32'h5A3C_96E1;
        mk_list[0] = 32'hFFFF_FFFF;
        mk_list[1] = 32'h0000_0000;
        mk_list[2] = 32'hC3A5_7E18;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1", "line_oe", line_oe, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "rx_word", rx_word, 0);
        chk("R1", "flags", {stat_done, stat_nopres, irq}, 0);

        // R2: strobe with neither request is ignored.
        issue(1'b0, 1'b0, 2'd3, 1'b0, 32'h1234_5678, 1'b1);
        repeat (20) @(negedge clk);
        chk("R2", "busy after empty command", busy, 0);
        chk("R2", "pulses after empty command", np, 0);
        chk("R2", "flags after empty command", {stat_done, stat_nopres}, 0);

        // R3, R4, R10: reset only, slave present then absent.
        run_cmd(1'b1, 1'b0, 2'd0, 1'b0, 32'h0, '1, 1'b1);
        slv_present = 1'b0;
        issue(1'b1, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1);
        wait_idle();
        chk("R4", "no-presence flag absent slave", stat_nopres, 1);
        chk("R10", "done after reset only", stat_done, 1);

        // R12: interrupt combining.
        irq_en_done = 1'b0; irq_en_nopres = 1'b0;
        @(negedge clk);
        chk("R12", "irq all disabled", irq, 0);
        irq_en_nopres = 1'b1;
        @(negedge clk);
        chk("R12", "irq via no-presence", irq, 1);
        irq_en_nopres = 1'b0; irq_en_done = 1'b1;
        @(negedge clk);
        chk("R12", "irq via done", irq, 1);

        // R11: clears act one flag at a time and flags persist otherwise.
        repeat (10) @(negedge clk);
        chk("R11", "flags persist", {stat_done, stat_nopres}, 2'b11);
        stat_clr = 2'b10;
        @(negedge clk);
        stat_clr = 2'b00;
        @(negedge clk);
        chk("R11", "clear no-presence only", {stat_done, stat_nopres}, 2'b10);
        stat_clr = 2'b01;
        @(negedge clk);
        stat_clr = 2'b00;
        @(negedge clk);
        chk("R11", "clear done", {stat_done, stat_nopres}, 2'b00);
        chk("R12", "irq after clear", irq, 0);
        irq_en_done = 1'b0;

        // R5: skip bit masks a missing response.
        run_cmd(1'b1, 1'b0, 2'd0, 1'b1, 32'h0, '1, 1'b0);

        // R6, R7, R8: sweep sizes, transmit patterns and slave responses.
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 2; t++)
                for (int m = 0; m < 3; m++)
                    run_cmd(1'b0, 1'b1, 2'(s), 1'b0, tx_list[t], mk_list[m], 1'b1);

        // R8: smaller transfer after a full one leaves upper bytes zero.
        run_cmd(1'b0, 1'b1, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);

        // R9: chained reset and transfer, with and without presence.
        run_cmd(1'b1, 1'b1, 2'd1, 1'b0, 32'hF0F0_C3FF, 32'hFFFF_0F5A, 1'b1);
        run_cmd(1'b1, 1'b1, 2'd0, 1'b0, 32'h0000_00B7, 32'hFFFF_FFFF, 1'b0);
        run_cmd(1'b1, 1'b1, 2'd0, 1'b1, 32'h0000_006D, 32'h0000_00F0, 1'b0);

        // R2: command strobed while busy is ignored.
        slv_mask = '1;
        slv_present = 1'b1;
        issue(1'b0, 1'b1, 2'd0, 1'b0, 32'h0000_00A5, 1'b1);
        repeat (100) @(negedge clk);
        issue(1'b1, 1'b1, 2'd3, 1'b0, 32'hFFFF_FFFF, 1'b0);
        wait_idle();
        chk("R2", "rx after busy strobe", rx_word, 32'h0000_00A5);
        chk("R2", "pulses after busy strobe", np, 8);
        chk("R2", "busy cycles after busy strobe", busy_cyc, 8 * 70 * DIV);
        clear_flags();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule